// File: doc/BRIEF.md
# Byte-Wide Flash Command Sequence Decoder

This block is the command interpreter on the device side of a byte-wide NOR flash model. Each synchronous write strobe carries a 20-bit address and a data byte. The decoder follows the two-write unlock prefix and recognises these commands:

- byte program
- sector erase, block erase and chip erase
- identification entry
- query entry
- return to array read

For every accepted program or erase it raises a single-clock start pulse that carries the operation, its target address and a data byte. It also keeps the current read mode: array, identification or query. While the identification mode is active, it returns the manufacturer and device bytes on a separate read path.

The sequence is tracked by a state machine with seven states:

| State | Meaning |
|---|---|
| `ST_IDLE` | No sequence in progress |
| `ST_KEY1` | First key accepted |
| `ST_CMD` | Both keys accepted, waiting for the command byte |
| `ST_PROG` | Program armed, waiting for the target write |
| `ST_ERA1` | Erase armed, waiting for the repeated first key |
| `ST_ERA2` | Waiting for the repeated second key |
| `ST_ERA3` | Waiting for the erase selector |

Transitions on an accepted write:

| From | Write | Next state | Effect |
|---|---|---|---|
| `ST_IDLE` | first key | `ST_KEY1` | none |
| `ST_IDLE` | F0h at any address | stays in `ST_IDLE` | mode set to array |
| `ST_IDLE` | any other write | stays in `ST_IDLE` | none |
| `ST_KEY1` | second key | `ST_CMD` | none |
| `ST_CMD` | A0h at the command address | `ST_PROG` | none |
| `ST_CMD` | 80h at the command address | `ST_ERA1` | none |
| `ST_CMD` | 90h at the command address | `ST_IDLE` | mode set to identification |
| `ST_CMD` | 98h at the command address | `ST_IDLE` | mode set to query |
| `ST_PROG` | any write | `ST_IDLE` | start pulse for a program |
| `ST_ERA1` | first key | `ST_ERA2` | none |
| `ST_ERA2` | second key | `ST_ERA3` | none |
| `ST_ERA3` | valid selector | `ST_IDLE` | start pulse for a chip, sector or block erase |

A write that does not fit the current step aborts to `ST_IDLE` and sets the mode to array. Any state left through an unlisted code also falls back to `ST_IDLE`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A synchronous reset leaves `read_mode` at array (0), `start` low, `id_data` at 00h, and no sequence in progress.
- R2: In command writes, only address bits 14..0 are compared. The first key is AAh at 5555h and the second key is 55h at 2AAAh. Bits 19..15 have no effect.
- R3: After the keys, A0h at 5555h arms a program. The next write raises `start` with `start_op`=1 and that write's address and data. The pulse appears in the clock after that write's edge.
- R4: A six-write erase sequence (keys, 80h at 5555h, keys, then 10h at 5555h) raises `start` with `start_op`=2 and address 0. If 10h arrives at any other address, the sequence aborts.
- R5: If the sixth erase write is 30h, `start_op`=3 and the address has bits 11..0 cleared. If it is 50h, `start_op`=4 and the address has bits 15..0 cleared. For both, any address is accepted and `start_data` carries the sixth byte.
- R6: After the keys, 90h at 5555h sets `read_mode` to identification (1), and 98h at 5555h sets it to query (2). A program or an erase leaves `read_mode` unchanged.
- R7: `id_data` is BFh when `rd_en` is high, the mode is identification and `rd_addr` is 0. It is D8h under the same conditions with `rd_addr` equal to 1. In every other case it is 00h.
- R8: Outside a sequence, a single write of F0h to any address sets `read_mode` to array. The three-write form (keys, then F0h at 5555h) has the same effect.
- R9: A wrong address or byte at any step after the first key aborts the sequence. There is no start, the mode becomes array, and the next write is decoded as a fresh first write.
- R10: While `busy` is high, every write is ignored, including the exit command. The mode and any partial sequence are kept, so a sequence resumes once `busy` falls.
- R11: Read strobes between the writes of a sequence do not disturb it.
- R12: `start` is high for exactly one clock per accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one clock per bus write |
| wr_addr | input | 20 | Write address |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 20 | Read address |
| busy | input | 1 | Internal operation in progress; writes are ignored |
| start | output | 1 | One-clock operation start pulse |
| start_op | output | 3 | 0 none, 1 program, 2 chip erase, 3 sector erase, 4 block erase |
| start_addr | output | 20 | Target address of the started operation |
| start_data | output | 8 | Program byte, or the erase selector byte |
| read_mode | output | 2 | 0 array, 1 identification, 2 query |
| id_data | output | 8 | Identification byte |

## Verification
The hardest case to reach is a wrong write deep in the erase path. When it arrives, the abort, the return to `ST_IDLE` and the fresh decode of the following writes all have to agree.

The bench drives the abort at every erase step with each of the 256 byte values. Each run starts from identification mode, so an abort shows up on `read_mode`. Each run then finishes the remaining writes of a chip erase, so any state left behind would produce a start.

In the same way, the bench sweeps each address bit of both keys and every byte in the command and selector positions. It also places `busy` in the middle of a partly entered sequence to show that the sequence resumes once `busy` falls.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_CMD,
        ST_PROG,
        ST_ERA1,
        ST_ERA2,
        ST_ERA3
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_CHIP   = 3'd2,
        OP_SECTOR = 3'd3,
        OP_BLOCK  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        MODE_ARRAY = 2'd0,
        MODE_ID    = 2'd1,
        MODE_QUERY = 2'd2
    } mode_e;

    localparam logic [7:0] KEY_BYTE1  = 8'hAA;
    localparam logic [7:0] KEY_BYTE2  = 8'h55;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_ERASE  = 8'h80;
    localparam logic [7:0] CMD_ID     = 8'h90;
    localparam logic [7:0] CMD_QUERY  = 8'h98;
    localparam logic [7:0] CMD_EXIT   = 8'hF0;
    localparam logic [7:0] SEL_CHIP   = 8'h10;
    localparam logic [7:0] SEL_SECTOR = 8'h30;
    localparam logic [7:0] SEL_BLOCK  = 8'h50;

endpackage

// File: rtl/fcd_classify.sv
module fcd_classify #(
    parameter int               CMD_AW = 15,
    parameter int               DATA_W = 8,
    parameter logic [CMD_AW-1:0] KEY_A1 = 15'h5555,
    parameter logic [CMD_AW-1:0] KEY_A2 = 15'h2AAA
) (
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [DATA_W-1:0] data,
    output logic              at_key_a1,
    output logic              hit_key1,
    output logic              hit_key2
);
    import fcd_pkg::*;

    logic at_key_a2;

    always_comb begin
        at_key_a1 = (cmd_addr == KEY_A1);
        at_key_a2 = (cmd_addr == KEY_A2);
        hit_key1  = at_key_a1 && (data == DATA_W'(KEY_BYTE1));
        hit_key2  = at_key_a2 && (data == DATA_W'(KEY_BYTE2));
    end

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm #(
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 8,
    parameter int SEC_LSB = 12,
    parameter int BLK_LSB = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              at_key_a1,
    input  logic              hit_key1,
    input  logic              hit_key2,
    output logic              start,
    output fcd_pkg::op_e      start_op,
    output logic [ADDR_W-1:0] start_addr,
    output logic [DATA_W-1:0] start_data,
    output fcd_pkg::mode_e    mode
);
    import fcd_pkg::*;

    localparam logic [ADDR_W-1:0] SEC_MASK = {ADDR_W{1'b1}} << SEC_LSB;
    localparam logic [ADDR_W-1:0] BLK_MASK = {ADDR_W{1'b1}} << BLK_LSB;

    seq_state_e        state, nstate;
    mode_e             nmode;
    logic              fire;
    op_e               fop;
    logic [ADDR_W-1:0] faddr;

    // Next-state and next-output decode
    always_comb begin
        nstate = state;
        nmode  = mode;
        fire   = 1'b0;
        fop    = OP_NONE;
        faddr  = addr;
        if (wr_go) begin
            unique case (state)
                ST_IDLE: begin
                    if (hit_key1) begin
                        nstate = ST_KEY1;
                    end else if (data == DATA_W'(CMD_EXIT)) begin
                        nmode = MODE_ARRAY;
                    end
                end
                ST_KEY1: begin
                    if (hit_key2) begin
                        nstate = ST_CMD;
                    end else begin
                        nstate = ST_IDLE;
                        nmode  = MODE_ARRAY;
                    end
                end
                ST_CMD: begin
                    nstate = ST_IDLE;
                    if (!at_key_a1) begin
                        nmode = MODE_ARRAY;
                    end else begin
                        case (data)
                            DATA_W'(CMD_PROG):  nstate = ST_PROG;
                            DATA_W'(CMD_ERASE): nstate = ST_ERA1;
                            DATA_W'(CMD_ID):    nmode  = MODE_ID;
                            DATA_W'(CMD_QUERY): nmode  = MODE_QUERY;
                            default:            nmode  = MODE_ARRAY;
                        endcase
                    end
                end
                ST_PROG: begin
                    nstate = ST_IDLE;
                    fire   = 1'b1;
                    fop    = OP_PROG;
                end
                ST_ERA1: begin
                    if (hit_key1) begin
                        nstate = ST_ERA2;
                    end else begin
                        nstate = ST_IDLE;
                        nmode  = MODE_ARRAY;
                    end
                end
                ST_ERA2: begin
                    if (hit_key2) begin
                        nstate = ST_ERA3;
                    end else begin
                        nstate = ST_IDLE;
                        nmode  = MODE_ARRAY;
                    end
                end
                ST_ERA3: begin
                    nstate = ST_IDLE;
                    if (at_key_a1 && data == DATA_W'(SEL_CHIP)) begin
                        fire  = 1'b1;
                        fop   = OP_CHIP;
                        faddr = '0;
                    end else if (data == DATA_W'(SEL_SECTOR)) begin
                        fire  = 1'b1;
                        fop   = OP_SECTOR;
                        faddr = addr & SEC_MASK;
                    end else if (data == DATA_W'(SEL_BLOCK)) begin
                        fire  = 1'b1;
                        fop   = OP_BLOCK;
                        faddr = addr & BLK_MASK;
                    end else begin
                        nmode = MODE_ARRAY;
                    end
                end
                default: begin
                    nstate = ST_IDLE;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            start      <= 1'b0;
            start_op   <= OP_NONE;
            start_addr <= '0;
            start_data <= '0;
            mode       <= MODE_ARRAY;
        end else begin
            start    <= fire;
            start_op <= fop;
            mode     <= nmode;
            if (fire) begin
                start_addr <= faddr;
                start_data <= data;
            end
        end
    end

endmodule

// File: rtl/fcd_id_read.sv
module fcd_id_read #(
    parameter int              ADDR_W = 20,
    parameter int              DATA_W = 8,
    parameter logic [DATA_W-1:0] MFR_ID = 8'hBF,
    parameter logic [DATA_W-1:0] DEV_ID = 8'hD8
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  fcd_pkg::mode_e    mode,
    output logic [DATA_W-1:0] id_data
);
    import fcd_pkg::*;

    logic offset_ok;

    always_comb begin
        offset_ok = (rd_addr[ADDR_W-1:1] == '0);
        if (rd_en && mode == MODE_ID && offset_ok) begin
            id_data = rd_addr[0] ? DEV_ID : MFR_ID;
        end else begin
            id_data = '0;
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 8,
    parameter int CMD_AW  = 15,
    parameter int SEC_LSB = 12,
    parameter int BLK_LSB = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              busy,
    output logic              start,
    output logic [2:0]        start_op,
    output logic [ADDR_W-1:0] start_addr,
    output logic [DATA_W-1:0] start_data,
    output logic [1:0]        read_mode,
    output logic [DATA_W-1:0] id_data
);
    import fcd_pkg::*;

    logic  wr_go;
    logic  at_key_a1, hit_key1, hit_key2;
    op_e   op_q;
    mode_e mode_q;

    assign wr_go = wr_en && !busy;

    fcd_classify #(
        .CMD_AW (CMD_AW),
        .DATA_W (DATA_W)
    ) u_classify (
        .cmd_addr  (wr_addr[CMD_AW-1:0]),
        .data      (wr_data),
        .at_key_a1 (at_key_a1),
        .hit_key1  (hit_key1),
        .hit_key2  (hit_key2)
    );

    fcd_seq_fsm #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .SEC_LSB (SEC_LSB),
        .BLK_LSB (BLK_LSB)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .wr_go      (wr_go),
        .addr       (wr_addr),
        .data       (wr_data),
        .at_key_a1  (at_key_a1),
        .hit_key1   (hit_key1),
        .hit_key2   (hit_key2),
        .start      (start),
        .start_op   (op_q),
        .start_addr (start_addr),
        .start_data (start_data),
        .mode       (mode_q)
    );

    fcd_id_read #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_id (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .mode    (mode_q),
        .id_data (id_data)
    );

    assign start_op  = op_q;
    assign read_mode = mode_q;

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 8,
    parameter int SEC_LSB = 12,
    parameter int BLK_LSB = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic              busy,
    input logic              start,
    input logic [2:0]        start_op,
    input logic [ADDR_W-1:0] start_addr,
    input logic [1:0]        read_mode,
    input logic [DATA_W-1:0] id_data
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!start && read_mode == 2'd0));

    p_pulse_single_r12: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    p_pulse_has_op_r12: assert property (@(posedge clk) disable iff (rst)
        start |-> (start_op != 3'd0));

    p_busy_no_start_r10: assert property (@(posedge clk) disable iff (rst)
        start |-> $past(wr_en && !busy));

    p_busy_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(read_mode));

    p_chip_addr_r4: assert property (@(posedge clk) disable iff (rst)
        (start && start_op == 3'd2) |-> (start_addr == '0));

    p_sector_align_r5: assert property (@(posedge clk) disable iff (rst)
        (start && start_op == 3'd3) |-> (start_addr[SEC_LSB-1:0] == '0));

    p_block_align_r5: assert property (@(posedge clk) disable iff (rst)
        (start && start_op == 3'd4) |-> (start_addr[BLK_LSB-1:0] == '0));

    p_id_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (id_data != '0) |-> (rd_en && read_mode == 2'd1));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SEC_LSB (SEC_LSB),
    .BLK_LSB (BLK_LSB)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .busy       (busy),
    .start      (start),
    .start_op   (start_op),
    .start_addr (start_addr),
    .read_mode  (read_mode),
    .id_data    (id_data)
);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [19:0] rd_addr = '0;
    logic        busy = 1'b0;
    logic        start;
    logic [2:0]  start_op;
    logic [19:0] start_addr;
    logic [7:0]  start_data;
    logic [1:0]  read_mode;
    logic [7:0]  id_data;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    flash_cmd_decoder u0 (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .busy       (busy),
        .start      (start),
        .start_op   (start_op),
        .start_addr (start_addr),
        .start_data (start_data),
        .read_mode  (read_mode),
        .id_data    (id_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One bus write; returns at the negedge after the capturing edge
    task automatic wr(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic keys();
        wr(20'h05555, 8'hAA);
        wr(20'h02AAA, 8'h55);
    endtask

    task automatic enter_id();
        keys();
        wr(20'h05555, 8'h90);
        chk("R6 id entry", read_mode, 2'd1);
    endtask

    task automatic idle_pulse();
        @(negedge clk);
        chk("R12 pulse ends", start, 1'b0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic [19:0] a;
        logic        exp_fire;
        logic [2:0]  exp_op;
        logic [19:0] exp_addr;
        logic [1:0]  exp_mode;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 start", start, 1'b0);
        chk("R1 mode", read_mode, 2'd0);
        chk("R1 id_data", id_data, 8'h00);

        // R3 program with upper address bits set on command writes (R2)
        wr(20'hF5555, 8'hAA);
        wr(20'h72AAA, 8'h55);
        wr(20'h85555, 8'hA0);
        chk("R3 no early start", start, 1'b0);
        wr(20'h9ABCD, 8'h5A);
        chk("R3 start", start, 1'b1);
        chk("R3 op", start_op, 3'd1);
        chk("R3 addr", start_addr, 20'h9ABCD);
        chk("R3 data", start_data, 8'h5A);
        chk("R6 mode kept by program", read_mode, 2'd0);
        idle_pulse();

        // R2 / R9 key address bit sweep, on first and second key
        for (int step = 0; step < 2; step++) begin
            for (int b = 0; b < 20; b++) begin
                a = (step == 0 ? 20'h05555 : 20'h02AAA) ^ (20'h1 << b);
                if (step == 0) begin
                    wr(a, 8'hAA);
                    wr(20'h02AAA, 8'h55);
                end else begin
                    wr(20'h05555, 8'hAA);
                    wr(a, 8'h55);
                end
                wr(20'h05555, 8'hA0);
                wr(20'h12345, 8'h3C);
                chk(b >= 15 ? "R2 high bits ignored" : "R9 key address abort",
                    start, (b >= 15) ? 1'b1 : 1'b0);
                idle_pulse();
            end
        end

        // Command byte sweep from identification mode (R3 R4 R6 R8 R9)
        for (int v = 0; v < 256; v++) begin
            d = v[7:0];
            enter_id();
            keys();
            wr(20'h05555, d);
            exp_mode = (d == 8'h90 || d == 8'hA0 || d == 8'h80) ? 2'd1 :
                       (d == 8'h98) ? 2'd2 : 2'd0;
            chk(d == 8'hF0 ? "R8 three-write exit" : "R6 R9 command byte", read_mode, exp_mode);
            chk("R9 no start on command", start, 1'b0);
            if (d == 8'hA0) begin
                wr(20'h4C3B2, 8'hE1);
                chk("R3 start after A0", start, 1'b1);
                chk("R3 addr after A0", start_addr, 20'h4C3B2);
                chk("R6 program keeps id mode", read_mode, 2'd1);
                idle_pulse();
            end else if (d == 8'h80) begin
                keys();
                wr(20'h05555, 8'h10);
                chk("R4 chip start", start, 1'b1);
                chk("R4 chip op", start_op, 3'd2);
                idle_pulse();
            end
        end

        // Abort sweep on the repeated keys of the erase path (R9)
        for (int step = 0; step < 2; step++) begin
            for (int v = 0; v < 256; v++) begin
                d = v[7:0];
                enter_id();
                keys();
                wr(20'h05555, 8'h80);
                if (step == 0) begin
                    wr(20'h05555, d);
                    wr(20'h02AAA, 8'h55);
                    exp_fire = (d == 8'hAA);
                end else begin
                    wr(20'h05555, 8'hAA);
                    wr(20'h02AAA, d);
                    exp_fire = (d == 8'h55);
                end
                wr(20'h05555, 8'h10);
                chk("R9 erase key abort start", start, exp_fire);
                chk("R9 erase key abort mode", read_mode, exp_fire ? 2'd1 : 2'd0);
                idle_pulse();
            end
        end

        // Sixth-write selector sweep at two addresses (R4 R5 R9)
        for (int k = 0; k < 2; k++) begin
            a = (k == 0) ? 20'h05555 : 20'hABCDE;
            for (int v = 0; v < 256; v++) begin
                d = v[7:0];
                keys();
                wr(20'h05555, 8'h80);
                keys();
                wr(a, d);
                exp_fire = 1'b0;
                exp_op   = 3'd0;
                exp_addr = 20'h0;
                if (d == 8'h10 && a[14:0] == 15'h5555) begin
                    exp_fire = 1'b1; exp_op = 3'd2; exp_addr = 20'h0;
                end else if (d == 8'h30) begin
                    exp_fire = 1'b1; exp_op = 3'd3; exp_addr = a & 20'hFF000;
                end else if (d == 8'h50) begin
                    exp_fire = 1'b1; exp_op = 3'd4; exp_addr = a & 20'hF0000;
                end
                chk("R4 R5 selector start", start, exp_fire);
                if (exp_fire) begin
                    chk("R5 selector op", start_op, exp_op);
                    chk("R5 selector addr", start_addr, exp_addr);
                    chk("R5 selector data", start_data, d);
                end
                idle_pulse();
            end
        end

        // Single writes outside a sequence from identification mode (R8)
        for (int v = 0; v < 256; v++) begin
            d = v[7:0];
            enter_id();
            wr(20'h01234, d);
            chk("R8 single write", read_mode, (d == 8'hF0) ? 2'd0 : 2'd1);
            wr(20'h01234, 8'hF0);
        end
        keys();
        wr(20'h05555, 8'h98);
        chk("R6 query entry", read_mode, 2'd2);
        wr(20'hFFFFF, 8'hF0);
        chk("R8 exit from query", read_mode, 2'd0);

        // Identification reads (R7)
        for (int m = 0; m < 2; m++) begin
            if (m == 1) enter_id();
            for (int r = 0; r < 2; r++) begin
                for (int i = 0; i < 6; i++) begin
                    @(negedge clk);
                    rd_en   = r[0];
                    rd_addr = (i < 4) ? 20'(i) : (20'h80000 | 20'(i - 4));
                    #2;
                    chk("R7 id read", id_data,
                        (m == 1 && r == 1 && i == 0) ? 8'hBF :
                        (m == 1 && r == 1 && i == 1) ? 8'hD8 : 8'h00);
                end
            end
        end
        @(negedge clk);
        rd_en = 1'b0;

        // Reads inside a sequence (R11)
        wr(20'h01234, 8'hF0);
        wr(20'h05555, 8'hAA);
        @(negedge clk); rd_en = 1'b1; rd_addr = 20'h00000;
        @(negedge clk); rd_en = 1'b0;
        wr(20'h02AAA, 8'h55);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        wr(20'h05555, 8'hA0);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        wr(20'h00777, 8'h81);
        chk("R11 program after reads", start, 1'b1);
        chk("R11 program addr", start_addr, 20'h00777);
        idle_pulse();

        // Busy (R10)
        enter_id();
        @(negedge clk); busy = 1'b1;
        wr(20'h01234, 8'hF0);
        chk("R10 single exit ignored", read_mode, 2'd1);
        keys();
        wr(20'h05555, 8'hF0);
        chk("R10 three-write exit ignored", read_mode, 2'd1);
        @(negedge clk); busy = 1'b0;
        wr(20'h01234, 8'hF0);
        chk("R8 exit after busy", read_mode, 2'd0);
        keys();
        @(negedge clk); busy = 1'b1;
        wr(20'h00000, 8'h00);
        chk("R10 abort ignored", read_mode, 2'd0);
        @(negedge clk); busy = 1'b0;
        wr(20'h05555, 8'h98);
        chk("R10 sequence resumes", read_mode, 2'd2);
        keys();
        wr(20'h05555, 8'hA0);
        @(negedge clk); busy = 1'b1;
        wr(20'h11111, 8'h22);
        chk("R10 program write ignored", start, 1'b0);
        @(negedge clk); busy = 1'b0;
        wr(20'h33333, 8'h44);
        chk("R10 program after busy", start, 1'b1);
        chk("R10 program addr", start_addr, 20'h33333);
        chk("R10 program data", start_data, 8'h44);
        idle_pulse();

        // Mid-sequence reset (R1)
        enter_id();
        keys();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 mode after reset", read_mode, 2'd0);
        wr(20'h05555, 8'hA0);
        wr(20'h05678, 8'h99);
        chk("R1 sequence cleared", start, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule